// File: doc/BRIEF.md
# Brown-Out Event Qualifier

This block sits between an asynchronous brown-out detector and the rest of the chip. It decides whether a detector assertion is a real supply dip, and then forwards it as either a reset request or an interrupt request. The detector signal first passes through a two-flop synchronizer into the internal-oscillator clock domain. Every other part of the block also runs on that clock.

A 32-bit control word configures the block through a simple register port. The port has an address, a write strobe and write data, and read data returns combinationally. The word holds three settings:

- a wait-and-resample enable,
- a reset-or-interrupt select,
- a 14-bit delay in oscillator periods.

When resampling is on, the first assertion starts the delay counter. When the count runs out, the detector is looked at once more. The event is reported only if the detector is still high at that sample; otherwise it is dropped as noise. When resampling is off, every qualified assertion is reported at once.

Top module: `bo_qualifier`

## Requirements
- R1: The control word is decoded at byte offset 0x030 and resets to 0x00007FFD. A read at any other offset returns 0.
- R2: A write at 0x030 updates bits 15:0. Bits 31:16 always read back as 0, whatever was written.
- R3: Bit 0 is the wait-and-resample enable. Bit 1 selects the reporting path: 1 gives a reset request, 0 gives an interrupt request. Bits 15:2 hold the delay count D.
- R4: With bit 0 clear, if the detector input is first seen high at rising edge N, the selected output is high in the cycle that follows edge N+2.
- R5: With bit 0 set and the input still high at edge N+D+1, the selected output is high in the cycle that follows edge N+D+3.
- R6: With bit 0 set and the input low at edge N+D+1, no output pulses. The block is then ready at once for a new assertion.
- R7: Each request is a single-cycle pulse, and the two outputs are never high together.
- R8: Further assertions while a wait is running do not restart the count.
- R9: After a reported event, no new qualification starts until the synchronized detector has been seen low.
- R10: A delay of 0 resamples on the next cycle. The 14-bit field can count past 10,000 periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| bo_async_i | input | 1 | Raw brown-out detector output |
| rst_req_o | output | 1 | Confirmed brown-out, reset path |
| irq_req_o | output | 1 | Confirmed brown-out, interrupt path |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 14-bit delay field and two synchronizer stages. The short delays (0, 5, 8) let the bench check the exact cycle of each pulse, the noise drop and the no-restart rule, all within a few cycles. A delay of 10,001 exercises the full field width within the run-time limit, and confirms that the counter reaches past the required 10,000-period window.

// File: rtl/bo_pkg.sv
package bo_pkg;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'd0,
        QS_WAIT  = 2'd1,
        QS_REARM = 2'd2
    } qual_state_e;

endpackage

// File: rtl/bo_sync.sv
module bo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bo_ctrl_reg.sv
module bo_ctrl_reg #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OFFSET = 8'h30,
    parameter int              DLY_W    = 14,
    parameter logic [DLY_W-1:0] DLY_INIT = 14'h1FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [DLY_W-1:0]  dly,
    output logic              sel_rst,
    output logic              wait_en
);
    localparam int LOW_W = DLY_W + 2;

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic             sel_rst;
        logic             wait_en;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  hit;

    assign hit = (reg_addr == OFFSET);

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_wr_en && hit) begin
            ctrl_d = ctrl_t'(reg_wdata[LOW_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.dly     <= DLY_INIT;
            ctrl_q.sel_rst <= 1'b0;
            ctrl_q.wait_en <= 1'b1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit) reg_rdata[LOW_W-1:0] = ctrl_q;
    end

    assign dly     = ctrl_q.dly;
    assign sel_rst = ctrl_q.sel_rst;
    assign wait_en = ctrl_q.wait_en;
endmodule

// File: rtl/bo_qual_fsm.sv
module bo_qual_fsm
    import bo_pkg::*;
#(
    parameter int DLY_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_i,
    input  logic             wait_en,
    input  logic             sel_rst,
    input  logic [DLY_W-1:0] dly,
    output logic             rst_req_o,
    output logic             irq_req_o
);
    typedef struct packed {
        qual_state_e      st;
        logic [DLY_W-1:0] cnt;
        logic             rst;
        logic             irq;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.rst = 1'b0;
        s_d.irq = 1'b0;
        unique case (s_q.st)
            QS_IDLE: begin
                if (det_i) begin
                    if (wait_en) begin
                        s_d.st  = QS_WAIT;
                        s_d.cnt = dly;
                    end else begin
                        s_d.rst = sel_rst;
                        s_d.irq = !sel_rst;
                        s_d.st  = QS_REARM;
                    end
                end
            end
            QS_WAIT: begin
                if (s_q.cnt == '0) begin
                    if (det_i) begin
                        s_d.rst = sel_rst;
                        s_d.irq = !sel_rst;
                        s_d.st  = QS_REARM;
                    end else begin
                        s_d.st  = QS_IDLE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            QS_REARM: begin
                if (!det_i) s_d.st = QS_IDLE;
            end
            default: s_d.st = QS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= QS_IDLE;
            s_q.cnt <= '0;
            s_q.rst <= 1'b0;
            s_q.irq <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rst_req_o = s_q.rst;
    assign irq_req_o = s_q.irq;
endmodule

// File: rtl/bo_qualifier.sv
module bo_qualifier #(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h30,
    parameter int                DLY_W       = 14,
    parameter logic [DLY_W-1:0]  DLY_INIT    = 14'h1FFF,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              bo_async_i,
    output logic              rst_req_o,
    output logic              irq_req_o
);
    logic [DLY_W-1:0] dly;
    logic             sel_rst;
    logic             wait_en;
    logic             sync_bo;

    bo_ctrl_reg #(
        .ADDR_W  (ADDR_W),
        .OFFSET  (CTRL_OFFSET),
        .DLY_W   (DLY_W),
        .DLY_INIT(DLY_INIT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .dly      (dly),
        .sel_rst  (sel_rst),
        .wait_en  (wait_en)
    );

    bo_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(bo_async_i),
        .sync_o (sync_bo)
    );

    bo_qual_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .det_i    (sync_bo),
        .wait_en  (wait_en),
        .sel_rst  (sel_rst),
        .dly      (dly),
        .rst_req_o(rst_req_o),
        .irq_req_o(irq_req_o)
    );
endmodule

// File: rtl/bo_qualifier_chk.sv
module bo_qualifier_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic        sync_bo,
    input logic        sel_rst,
    input logic        rst_req_o,
    input logic        irq_req_o
);
    // R2: reserved half always reads zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:16] == 16'h0);

    // R7: the two request outputs are mutually exclusive
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req_o && irq_req_o));

    // R7: single-cycle pulses
    a_r7_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |=> !irq_req_o);

    // R5: a request is only issued when the synchronized detector was high
    a_r5_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o || irq_req_o) |-> $past(sync_bo));

    // R3: path follows the select bit
    a_r3_rst_path: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(sel_rst));
    a_r3_irq_path: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> !$past(sel_rst));
endmodule

bind bo_qualifier bo_qualifier_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_rdata(reg_rdata),
    .sync_bo  (sync_bo),
    .sel_rst  (sel_rst),
    .rst_req_o(rst_req_o),
    .irq_req_o(irq_req_o)
);

// File: tb/bo_qualifier_tb.sv
module bo_qualifier_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        bo = 1'b0;
    logic        rst_req, irq_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bo_qualifier u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .bo_async_i(bo),
        .rst_req_o (rst_req),
        .irq_req_o (irq_req)
    );

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cfg(int d, bit sel, bit wt);
        return {16'h0, d[13:0], sel, wt};
    endfunction

    // Raise bo (second burst optional), count pulses, record first pulse index
    task automatic run(int hold, int gap, int hold2, int window,
                       output int first, output int nr, output int ni);
        first = -1; nr = 0; ni = 0;
        @(negedge clk);
        bo = 1'b1;
        for (int i = 1; i <= window; i++) begin
            @(negedge clk);
            if (rst_req || irq_req) begin
                if (first < 0) first = i;
            end
            if (rst_req) nr++;
            if (irq_req) ni++;
            if (i == hold) bo = 1'b0;
            if (hold2 > 0 && i == hold + gap) bo = 1'b1;
            if (hold2 > 0 && i == hold + gap + hold2) bo = 1'b0;
        end
        bo = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset_read();
        logic [31:0] d;
        rd(8'h30, d);  check("R1 reset value", d, 32'h0000_7FFD);
        rd(8'h34, d);  check("R1 other offset", d, 0);
    endtask

    task automatic t_write_read();
        logic [31:0] d;
        wr(8'h30, 32'hFFFF_0016);
        rd(8'h30, d);  check("R2 reserved ignored", d, 32'h0000_0016);
        wr(8'h2C, 32'h0000_0003);
        rd(8'h30, d);  check("R1 miss write ignored", d, 32'h0000_0016);
    endtask

    task automatic t_nowait(bit sel);
        int f, nr, ni;
        wr(8'h30, cfg(7, sel, 0));
        run(2, 0, 0, 12, f, nr, ni);
        check("R4 timing", f, 3);
        check("R3 reset count", nr, sel ? 1 : 0);
        check("R3 irq count", ni, sel ? 0 : 1);
    endtask

    task automatic t_wait_ok();
        int f, nr, ni;
        wr(8'h30, cfg(5, 0, 1));
        run(7, 0, 0, 20, f, nr, ni);
        check("R5 timing", f, 9);
        check("R5 irq count", ni, 1);
    endtask

    task automatic t_noise();
        int f, nr, ni;
        wr(8'h30, cfg(5, 1, 1));
        run(6, 0, 0, 20, f, nr, ni);
        check("R6 noise dropped", nr + ni, 0);
        run(7, 0, 0, 20, f, nr, ni);
        check("R6 rearmed after noise", f, 9);
        check("R6 rearmed reset count", nr, 1);
    endtask

    task automatic t_norestart();
        int f, nr, ni;
        wr(8'h30, cfg(8, 0, 1));
        // high 2, low 2, then high through resample at N+9
        run(2, 2, 10, 25, f, nr, ni);
        check("R8 no restart timing", f, 12);
        check("R8 single pulse", ni, 1);
    endtask

    task automatic t_rearm();
        int f, nr, ni;
        wr(8'h30, cfg(0, 1, 0));
        run(30, 0, 0, 35, f, nr, ni);
        check("R9 one pulse while held", nr, 1);
        check("R7 width", nr + ni, 1);
    endtask

    task automatic t_zero_delay();
        int f, nr, ni;
        wr(8'h30, cfg(0, 0, 1));
        run(3, 0, 0, 10, f, nr, ni);
        check("R10 zero delay timing", f, 4);
    endtask

    task automatic t_long();
        int f, nr, ni;
        logic [31:0] d;
        wr(8'h30, cfg(10001, 1, 1));
        rd(8'h30, d);  check("R10 field holds 10001", d[15:2], 10001);
        run(10005, 0, 0, 10010, f, nr, ni);
        check("R10 long delay timing", f, 10005);
        check("R10 long reset count", nr, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset outputs", {rst_req, irq_req}, 0);
        t_reset_read();
        t_write_read();
        t_nowait(0);
        t_nowait(1);
        t_wait_ok();
        t_noise();
        t_norestart();
        t_rearm();
        t_zero_delay();
        t_long();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule